// File: doc/BRIEF.md
# Stored-Vector Self-Test Stimulus Source

This block feeds built-in self-test stimulus to a row of I/O cells that serialize and deserialize data. A binary address counter walks a 512-word by 36-bit pattern store once from address 0 to address 511. Each word becomes one parallel test vector on the stimulus lines of the cells under test. The store holds three kinds of content: a short alignment training sequence, deterministic vectors and pseudorandom vectors. The contents are computed from the address, so no load step is needed.

Counter and store advance at the slow parallel word rate, not at the fast serial clock rate. A clock-enable divider running on the fast clock produces one step every N fast cycles. N follows the configured serialization width. While the training words are being fetched, the block raises an enable for the downstream word-alignment (bitslip) synchronizer. After the last word it raises a done flag that stays set until reset.

Top module: `bist_pattern_gen`

## Requirements
- R1: While reset is applied, and until the first word is delivered after reset, `vec_valid_o`=0, `done_o`=0, `sync_en_o`=1 and `vec_o`=0.
- R2: `width_sel_i` code c (3 bits, static while out of reset) selects a step ratio of c+2 for codes 0..6 and 10 for code 7. Consecutive `vec_valid_o` pulses are exactly that many `clk_i` cycles apart.
- R3: Each `vec_valid_o` pulse is one cycle wide.
- R4: After reset, the k-th pulse (k = 0..511) presents the word stored at address k, in ascending order.
- R5: Training words at addresses 0..15: an even address holds 36'hCCCCCCCCC and an odd address holds 36'h333333333.
- R6: Deterministic words at addresses 16..255 hold the 9-bit address repeated four times, so bit b equals address bit (b mod 9).
- R7: Pseudorandom words at addresses 256..511: p = (address × 36'h9E3779B97) mod 2^36, and the word is p XOR (p >> 17).
- R8: `sync_en_o` is high while the next address to fetch is below 16. During the pulse for word k it equals (k < 15). Once low, it stays low until reset.
- R9: `done_o` rises in the same cycle as the pulse for word 511 and stays high until reset.
- R10: Once `done_o` is high, no further `vec_valid_o` pulse occurs and `vec_o` keeps word 511.
- R11: A reset applied mid-pass restarts the pass: the next pulse carries word 0, with `sync_en_o` high and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast serial-rate clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| width_sel_i | input | 3 | Serialization width code selecting the step ratio |
| vec_o | output | 36 | Current test vector |
| vec_valid_o | output | 1 | One-cycle strobe marking a new vector on `vec_o` |
| sync_en_o | output | 1 | Enable for the word-alignment synchronizer during training |
| done_o | output | 1 | Sticky end-of-pass flag |

## Verification
The hardest situation to reach from the ports is the end of the pass under every step ratio. There, the last fetch, the done flag and the silence that must follow all meet. Each of the eight width codes is run for a complete 512-word pass. Every delivered word is compared with its arithmetic expectation, and the pulse spacing is measured. The bench then waits for several step periods to confirm that no further word appears. A separate run pulls reset after about a hundred words, which shows that the pass restarts at the first training word.

// File: rtl/bpg_pkg.sv
package bpg_pkg;

  localparam int WSEL_W  = 3;
  localparam int RATIO_W = 4;

  typedef logic [WSEL_W-1:0]  wsel_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  // Width code to fast-clock cycles per parallel word.
  function automatic ratio_t ratio_of(input wsel_t code);
    ratio_t r;
    if (code == wsel_t'(7)) r = ratio_t'(10);
    else                    r = ratio_t'(code) + ratio_t'(2);
    return r;
  endfunction

endpackage

// File: rtl/bpg_clk_div.sv
module bpg_clk_div
  import bpg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_n_i,
  input  wsel_t width_sel_i,
  output logic  step_o
);

  ratio_t cnt_q, cnt_d;
  ratio_t last_cnt;
  logic   wrap;

  assign last_cnt = ratio_of(width_sel_i) - ratio_t'(1);
  assign wrap     = (cnt_q >= last_cnt);

  always_comb begin
    cnt_d = cnt_q + ratio_t'(1);
    if (wrap) cnt_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) cnt_q <= '0;
    else          cnt_q <= cnt_d;
  end

  assign step_o = wrap;

endmodule

// File: rtl/bpg_addr_ctr.sv
module bpg_addr_ctr #(
  parameter int ADDR_W      = 9,
  parameter int TRAIN_WORDS = 16
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fetch_o,
  output logic              train_o,
  output logic              done_o
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] TRAIN_END = ADDR_W'(TRAIN_WORDS);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              fetch;

  assign fetch = step_i & ~done_q;

  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    if (fetch) begin
      if (addr_q == LAST_ADDR) done_d = 1'b1;
      else                     addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr_o  = addr_q;
  assign fetch_o = fetch;
  assign train_o = (addr_q < TRAIN_END) & ~done_q;
  assign done_o  = done_q;

endmodule

// File: rtl/bpg_pattern_rom.sv
module bpg_pattern_rom #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 36,
  parameter int TRAIN_WORDS = 16,
  parameter int DET_END     = 256,
  parameter int MIX_SHIFT   = 17
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);

  localparam logic [DATA_W-1:0] MIX_K     = DATA_W'(64'h9E3779B97);
  localparam logic [ADDR_W-1:0] TRAIN_END = ADDR_W'(TRAIN_WORDS);
  localparam logic [ADDR_W-1:0] DET_LIM   = ADDR_W'(DET_END);

  function automatic logic [DATA_W-1:0] word_at(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w;
    logic [DATA_W-1:0] p;
    w = '0;
    p = '0;
    if (a < TRAIN_END) begin
      for (int b = 0; b < DATA_W; b++) w[b] = ((b % 4) >= 2) ^ a[0];
    end else if (a < DET_LIM) begin
      for (int b = 0; b < DATA_W; b++) w[b] = a[b % ADDR_W];
    end else begin
      p = DATA_W'(a) * MIX_K;
      w = p ^ (p >> MIX_SHIFT);
    end
    return w;
  endfunction

  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q;

  always_comb begin
    data_d = data_q;
    if (rd_en_i) data_d = word_at(addr_i);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= rd_en_i;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen
  import bpg_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 36,
  parameter int TRAIN_WORDS = 16,
  parameter int DET_END     = 256
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [2:0]        width_sel_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_valid_o,
  output logic              sync_en_o,
  output logic              done_o
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n;
  logic              step;
  logic              fetch;
  logic              train;
  logic [ADDR_W-1:0] addr;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe_q <= 2'b00;
    else          rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  bpg_clk_div u_div (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n),
    .width_sel_i (wsel_t'(width_sel_i)),
    .step_o      (step)
  );

  bpg_addr_ctr #(
    .ADDR_W      (ADDR_W),
    .TRAIN_WORDS (TRAIN_WORDS)
  ) u_ctr (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .step_i  (step),
    .addr_o  (addr),
    .fetch_o (fetch),
    .train_o (train),
    .done_o  (done_o)
  );

  bpg_pattern_rom #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .TRAIN_WORDS (TRAIN_WORDS),
    .DET_END     (DET_END)
  ) u_rom (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .rd_en_i (fetch),
    .addr_i  (addr),
    .data_o  (vec_o),
    .valid_o (vec_valid_o)
  );

  assign sync_en_o = train;

endmodule

// File: rtl/bpg_checker.sv
module bpg_checker
  import bpg_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic [2:0]        width_sel_i,
  input logic [DATA_W-1:0] vec_o,
  input logic              vec_valid_o,
  input logic              sync_en_o,
  input logic              done_o
);

  ratio_t gap_q;
  logic   seen_q;

  // Cycles since the previous strobe, saturating.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (vec_valid_o) begin
      gap_q  <= ratio_t'(1);
      seen_q <= 1'b1;
    end else if (gap_q != {RATIO_W{1'b1}}) begin
      gap_q  <= gap_q + ratio_t'(1);
    end
  end

  assert_step_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (vec_valid_o && seen_q) |-> (gap_q == ratio_of(wsel_t'(width_sel_i))));

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    vec_valid_o |=> !vec_valid_o);

  assert_sync_stays_low_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !sync_en_o |=> !sync_en_o);

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> done_o);

  assert_silent_after_done_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> (!vec_valid_o && $stable(vec_o)));

  assert_vec_held_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !vec_valid_o |=> (vec_valid_o || $stable(vec_o)));

endmodule

bind bist_pattern_gen bpg_checker #(.DATA_W(DATA_W)) u_bpg_chk (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .width_sel_i (width_sel_i),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .sync_en_o   (sync_en_o),
  .done_o      (done_o)
);

// File: tb/tb_bist_pattern_gen.sv
module tb_bist_pattern_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  wsel;
  logic [35:0] vec;
  logic        vld, sen, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bist_pattern_gen dut (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .width_sel_i (wsel),
    .vec_o       (vec),
    .vec_valid_o (vld),
    .sync_en_o   (sen),
    .done_o      (done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
      summary();
    end
  end

  function automatic logic [35:0] exp_word(int i);
    logic [8:0]  a;
    longint unsigned p;
    a = 9'(i);
    if (i < 16) return (i % 2 == 0) ? 36'hCCCCCCCCC : 36'h333333333;
    if (i < 256) return {a, a, a, a};
    p = (longint'(i) * 64'h9E3779B97) & 64'hF_FFFF_FFFF;
    return 36'(p ^ (p >> 17));
  endfunction

  function automatic int ratio_exp(int c);
    return (c == 7) ? 10 : c + 2;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(int code);
    @(negedge clk);
    wsel  = 3'(code);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(vld == 0,  "R1 valid", vld, 0);
    check(done == 0, "R1 done", done, 0);
    check(sen == 1,  "R1 sync_en", sen, 1);
    check(vec == 0,  "R1 vec", vec, 0);
    rst_n = 1'b1;
  endtask

  // Collect up to `limit` words; returns number received.
  task automatic run_words(int code, int limit, output int got);
    int k = 0;
    int last = -1;
    int t = 0;
    while (k < limit && t < 20000) begin
      @(negedge clk);
      t++;
      if (vld) begin
        check(vec == exp_word(k), (k < 16) ? "R5 train" : (k < 256) ? "R6 det" : "R7 prn",
              vec, exp_word(k));
        if (k == 0) check(vec == exp_word(0), "R4 first word", vec, exp_word(0));
        if (last >= 0)
          check((t - last) == ratio_exp(code), "R2 spacing", t - last, ratio_exp(code));
        check(sen == (k < 15), "R8 sync_en", sen, (k < 15));
        check(done == (k == 511), "R9 done", done, (k == 511));
        last = t;
        k++;
      end else if (k == 0) begin
        check(sen == 1 && done == 0, "R1 pre-first", {sen, done}, 2);
      end else begin
        check(t - last < ratio_exp(code), "R3 gap bound", t - last, ratio_exp(code));
      end
    end
    got = k;
  endtask

  initial begin
    int got;
    rst_n = 1'b0;
    wsel  = 3'd0;
    for (int c = 0; c < 8; c++) begin
      do_reset(c);
      run_words(c, 512, got);
      check(got == 512, "R4 word count", got, 512);
      for (int w = 0; w < 3 * ratio_exp(c) + 5; w++) begin
        @(negedge clk);
        check(vld == 0, "R10 no strobe after done", vld, 0);
        check(vec == exp_word(511), "R10 vec held", vec, exp_word(511));
        check(done == 1, "R9 sticky", done, 1);
        check(sen == 0, "R8 stays low", sen, 0);
      end
    end
    // Mid-pass reset restarts the pass.
    do_reset(2);
    run_words(2, 100, got);
    check(got == 100, "R11 partial run", got, 100);
    do_reset(2);
    run_words(2, 20, got);
    check(got == 20, "R11 restart count", got, 20);
    finished = 1;
    summary();
  end

endmodule